// File: doc/BRIEF.md
# I2C Controller Control Register

This block is the 8-bit control register that sits between a simple peripheral write/read bus and the serial engine of an I2C controller. Software writes one byte to enable the controller, choose the acknowledge policy, pick a clock-rate code and request START or STOP conditions. The register returns its full contents on a combinational readback port.

The START and STOP request bits are commands, not plain storage. The engine clears them by pulsing a completion input. A START request is passed to the engine only while the bus is free, and a STOP request only while the controller is master. The interrupt flag is set by hardware alone when the engine reports a status change. Software can clear it but never set it, and the flag drives the interrupt line directly. When the controller is disabled, the serial output enables are forced off, the serial inputs seen by the engine are held at the idle level, and any pending command is dropped.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset every register bit reads 0. The readback bit positions are: bit 7 rate bit 2, bit 6 enable, bit 5 start request, bit 4 stop request, bit 3 interrupt flag, bit 2 acknowledge enable, bit 1 rate bit 1, bit 0 rate bit 0.
- R2: A bus write stores enable, acknowledge enable and the three rate bits. `rate_code` equals {bit 7, bit 1, bit 0} of the stored value and `ack_en` equals bit 2. Both are visible on the cycle after the write.
- R3: While enable is 0, `scl_oe` and `sda_oe` are 0, `eng_scl_in` and `eng_sda_in` are held at 1 whatever the pad inputs do, and status events do not set the interrupt flag. While enable is 1, the pads pass straight through.
- R4: A written start request stays pending. `start_cmd` is high only while enable is 1, the request is pending and `bus_free` is 1.
- R5: `eng_start_done` clears a pending start request on the next cycle.
- R6: `stop_cmd` is high only while enable is 1, a stop request is pending and `master_mode` is 1. `eng_stop_done` clears the request on the next cycle.
- R7: With enable at 1, an `eng_status_evt` pulse sets the interrupt flag. `irq` equals the flag.
- R8: Writing 0 to bit 3 clears the interrupt flag. Writing 1 to bit 3 leaves it unchanged, so software can never set it.
- R9: If a status event and a software clear of the flag fall in the same cycle, the flag ends up set.
- R10: When enable is 0, including a write that clears enable, any pending start or stop request is cancelled.
- R11: A write to a request bit in the same cycle as its completion pulse takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Register readback |
| eng_start_done | input | 1 | Engine has generated the START |
| eng_stop_done | input | 1 | Engine has generated the STOP |
| eng_status_evt | input | 1 | Engine status changed |
| bus_free | input | 1 | Serial bus is idle |
| master_mode | input | 1 | Controller currently owns the bus as master |
| start_cmd | output | 1 | START request to the engine |
| stop_cmd | output | 1 | STOP request to the engine |
| ack_en | output | 1 | Acknowledge (1) or not-acknowledge (0) for received bytes |
| rate_code | output | 3 | Clock-rate select to the rate generator |
| irq | output | 1 | Interrupt line |
| eng_scl_oe | input | 1 | Clock-line output enable from the engine |
| eng_sda_oe | input | 1 | Data-line output enable from the engine |
| scl_oe | output | 1 | Gated clock-line output enable to the pad |
| sda_oe | output | 1 | Gated data-line output enable to the pad |
| scl_pad_in | input | 1 | Clock-line pad input |
| sda_pad_in | input | 1 | Data-line pad input |
| eng_scl_in | output | 1 | Gated clock-line input to the engine |
| eng_sda_in | output | 1 | Gated data-line input to the engine |

## Verification
A request bit that fails to clear would keep `start_cmd` or `stop_cmd` high on the cycle after the completion pulse and show as a set bit in `ctrl_rd`. A cancel that does not happen would surface the moment enable returns. An interrupt flag that software can set, or that loses a same-cycle race with hardware, changes `irq` on the cycle right after the write. The gating paths are combinational, so a wrong enable state shows on the pad and engine pins in the same cycle.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
   localparam int CTRL_W = 8;
   localparam int RATE_W = 3;

   // readback positions: fixed because software decodes them
   localparam int BIT_RATE2 = 7;
   localparam int BIT_EN    = 6;
   localparam int BIT_START = 5;
   localparam int BIT_STOP  = 4;
   localparam int BIT_FLAG  = 3;
   localparam int BIT_ACK   = 2;
   localparam int BIT_RATE1 = 1;
   localparam int BIT_RATE0 = 0;

   // command latch indices
   localparam int CMD_START = 0;
   localparam int CMD_STOP  = 1;
   localparam int NCMD      = 2;

   // serial line indices
   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;
   localparam int NLINE    = 2;

   typedef struct packed {
      logic                enable;
      logic                ack;
      logic [RATE_W-1:0]   rate;
   } ctrl_plain_t;

   function automatic logic [RATE_W-1:0] rate_from_byte(input logic [CTRL_W-1:0] b);
      return {b[BIT_RATE2], b[BIT_RATE1], b[BIT_RATE0]};
   endfunction
endpackage

// File: rtl/i2c_ctl_cmd_latch.sv
module i2c_ctl_cmd_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic done,
   input  logic enable_next,
   output logic pend
);
   logic pend_d;

   always_comb begin
      pend_d = pend;
      if (done)         pend_d = 1'b0;
      if (wr_en)        pend_d = wr_val;
      if (!enable_next) pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_d;
   end
endmodule

// File: rtl/i2c_ctl_irq_flag.sv
module i2c_ctl_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (sw_clr) flag <= 1'b0;
   end
endmodule

// File: rtl/i2c_ctl_pad_gate.sv
module i2c_ctl_pad_gate #(
   parameter int NL       = 2,
   parameter bit IN_IDLE  = 1'b1
) (
   input  logic          enable,
   input  logic [NL-1:0] eng_oe,
   input  logic [NL-1:0] pad_in,
   output logic [NL-1:0] pad_oe,
   output logic [NL-1:0] eng_in
);
   for (genvar i = 0; i < NL; i++) begin : g_line
      assign pad_oe[i] = enable & eng_oe[i];
      assign eng_in[i] = enable ? pad_in[i] : IN_IDLE;
   end
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
   import i2c_ctl_pkg::*;
#(
   parameter int W       = CTRL_W,
   parameter int RW      = RATE_W,
   parameter bit IN_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr_en,
   input  logic [W-1:0]  bus_wr_data,
   output logic [W-1:0]  ctrl_rd,
   input  logic          eng_start_done,
   input  logic          eng_stop_done,
   input  logic          eng_status_evt,
   input  logic          bus_free,
   input  logic          master_mode,
   output logic          start_cmd,
   output logic          stop_cmd,
   output logic          ack_en,
   output logic [RW-1:0] rate_code,
   output logic          irq,
   input  logic          eng_scl_oe,
   input  logic          eng_sda_oe,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          scl_pad_in,
   input  logic          sda_pad_in,
   output logic          eng_scl_in,
   output logic          eng_sda_in
);
   if (W != CTRL_W) begin : g_bad_w
      $error("i2c_ctl_reg: register width must be %0d", CTRL_W);
   end
   if (RW != RATE_W) begin : g_bad_rw
      $error("i2c_ctl_reg: rate code width must be %0d", RATE_W);
   end

   ctrl_plain_t plain_q, plain_d;
   logic        enable_next;
   logic        flag;
   logic [NCMD-1:0] cmd_wr_val, cmd_done, cmd_pend;
   logic [NLINE-1:0] line_eng_oe, line_pad_in, line_pad_oe, line_eng_in;

   // plain storage bits
   always_comb begin
      plain_d = plain_q;
      if (bus_wr_en) begin
         plain_d.enable = bus_wr_data[BIT_EN];
         plain_d.ack    = bus_wr_data[BIT_ACK];
         plain_d.rate   = rate_from_byte(bus_wr_data);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plain_q <= '0;
      else        plain_q <= plain_d;
   end

   assign enable_next = plain_d.enable;

   // self-clearing command latches
   always_comb begin
      cmd_wr_val            = '0;
      cmd_done              = '0;
      cmd_wr_val[CMD_START] = bus_wr_data[BIT_START];
      cmd_wr_val[CMD_STOP]  = bus_wr_data[BIT_STOP];
      cmd_done[CMD_START]   = eng_start_done & plain_q.enable;
      cmd_done[CMD_STOP]    = eng_stop_done  & plain_q.enable;
   end

   for (genvar c = 0; c < NCMD; c++) begin : g_cmd
      i2c_ctl_cmd_latch u_latch (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_en       (bus_wr_en),
         .wr_val      (cmd_wr_val[c]),
         .done        (cmd_done[c]),
         .enable_next (enable_next),
         .pend        (cmd_pend[c])
      );
   end

   // interrupt flag: hardware sets, software clears by writing 0
   i2c_ctl_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (eng_status_evt & plain_q.enable),
      .sw_clr (bus_wr_en & ~bus_wr_data[BIT_FLAG]),
      .flag   (flag)
   );

   // serial line gating
   always_comb begin
      line_eng_oe           = '0;
      line_pad_in           = '0;
      line_eng_oe[LINE_SCL] = eng_scl_oe;
      line_eng_oe[LINE_SDA] = eng_sda_oe;
      line_pad_in[LINE_SCL] = scl_pad_in;
      line_pad_in[LINE_SDA] = sda_pad_in;
   end

   i2c_ctl_pad_gate #(.NL(NLINE), .IN_IDLE(IN_IDLE)) u_gate (
      .enable (plain_q.enable),
      .eng_oe (line_eng_oe),
      .pad_in (line_pad_in),
      .pad_oe (line_pad_oe),
      .eng_in (line_eng_in)
   );

   assign scl_oe     = line_pad_oe[LINE_SCL];
   assign sda_oe     = line_pad_oe[LINE_SDA];
   assign eng_scl_in = line_eng_in[LINE_SCL];
   assign eng_sda_in = line_eng_in[LINE_SDA];

   // outputs to the engine
   assign start_cmd = plain_q.enable & cmd_pend[CMD_START] & bus_free;
   assign stop_cmd  = plain_q.enable & cmd_pend[CMD_STOP]  & master_mode;
   assign ack_en    = plain_q.ack;
   assign rate_code = plain_q.rate;
   assign irq       = flag;

   // readback
   always_comb begin
      ctrl_rd            = '0;
      ctrl_rd[BIT_RATE2] = plain_q.rate[2];
      ctrl_rd[BIT_EN]    = plain_q.enable;
      ctrl_rd[BIT_START] = cmd_pend[CMD_START];
      ctrl_rd[BIT_STOP]  = cmd_pend[CMD_STOP];
      ctrl_rd[BIT_FLAG]  = flag;
      ctrl_rd[BIT_ACK]   = plain_q.ack;
      ctrl_rd[BIT_RATE1] = plain_q.rate[1];
      ctrl_rd[BIT_RATE0] = plain_q.rate[0];
   end
endmodule

// File: rtl/i2c_ctl_reg_chk.sv
module i2c_ctl_reg_chk
   import i2c_ctl_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic [CTRL_W-1:0] bus_wr_data,
   input logic [CTRL_W-1:0] ctrl_rd,
   input logic              eng_start_done,
   input logic              eng_stop_done,
   input logic              eng_status_evt,
   input logic              bus_free,
   input logic              master_mode,
   input logic              start_cmd,
   input logic              stop_cmd,
   input logic              ack_en,
   input logic [RATE_W-1:0] rate_code,
   input logic              irq,
   input logic              scl_oe,
   input logic              sda_oe
);
   a_r2_rate_stored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_en |=> (rate_code == rate_from_byte($past(bus_wr_data)))
                    && (ack_en == $past(bus_wr_data[BIT_ACK])));

   a_r3_pads_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rd[BIT_EN] |-> !scl_oe && !sda_oe);

   a_r4_start_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
      start_cmd |-> bus_free && ctrl_rd[BIT_EN]);

   a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd[BIT_START] && ctrl_rd[BIT_EN] && eng_start_done && !bus_wr_en
      |=> !ctrl_rd[BIT_START]);

   a_r6_stop_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |-> master_mode && ctrl_rd[BIT_EN]);

   a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      eng_status_evt && ctrl_rd[BIT_EN] |=> irq);

   a_r8_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !(eng_status_evt && ctrl_rd[BIT_EN]) |=> !irq);

   a_r10_disable_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rd[BIT_EN] |-> !ctrl_rd[BIT_START] && !ctrl_rd[BIT_STOP]);

   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_en && bus_wr_data[BIT_START] && bus_wr_data[BIT_EN]
      |=> ctrl_rd[BIT_START]);
endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_wr_en      (bus_wr_en),
   .bus_wr_data    (bus_wr_data),
   .ctrl_rd        (ctrl_rd),
   .eng_start_done (eng_start_done),
   .eng_stop_done  (eng_stop_done),
   .eng_status_evt (eng_status_evt),
   .bus_free       (bus_free),
   .master_mode    (master_mode),
   .start_cmd      (start_cmd),
   .stop_cmd       (stop_cmd),
   .ack_en         (ack_en),
   .rate_code      (rate_code),
   .irq            (irq),
   .scl_oe         (scl_oe),
   .sda_oe         (sda_oe)
);

// File: tb/i2c_ctl_reg_test.sv
`timescale 1ns/1ps
module i2c_ctl_reg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr_en = 1'b0;
   logic [7:0] bus_wr_data = 8'h00;
   logic [7:0] ctrl_rd;
   logic       eng_start_done = 1'b0, eng_stop_done = 1'b0, eng_status_evt = 1'b0;
   logic       bus_free = 1'b0, master_mode = 1'b0;
   logic       start_cmd, stop_cmd, ack_en, irq;
   logic [2:0] rate_code;
   logic       eng_scl_oe = 1'b0, eng_sda_oe = 1'b0;
   logic       scl_oe, sda_oe;
   logic       scl_pad_in = 1'b1, sda_pad_in = 1'b1;
   logic       eng_scl_in, eng_sda_in;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2c_ctl_reg uut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
      .ctrl_rd(ctrl_rd), .eng_start_done(eng_start_done), .eng_stop_done(eng_stop_done),
      .eng_status_evt(eng_status_evt), .bus_free(bus_free), .master_mode(master_mode),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .ack_en(ack_en), .rate_code(rate_code),
      .irq(irq), .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .scl_pad_in(scl_pad_in), .sda_pad_in(sda_pad_in),
      .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in));

   // {write data, expected readback}
   localparam int NVEC = 8;
   localparam logic [15:0] VEC [NVEC] = '{
      {8'h00, 8'h00},
      {8'h47, 8'h47},
      {8'h85, 8'h85},
      {8'h30, 8'h00},
      {8'h70, 8'h70},
      {8'h48, 8'h40},
      {8'hFF, 8'hF7},
      {8'hB7, 8'h87}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      bus_wr_en   = 1'b1;
      bus_wr_data = d;
      @(negedge clk);
      bus_wr_en   = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset readback", ctrl_rd, 8'h00);
      check("R1 reset irq", {7'd0, irq}, 8'h00);

      // vector table: R2 storage, R8 flag write-1, R10 cancel on disabled write
      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] e;
         e = VEC[i][7:0];
         wr(VEC[i][15:8]);
         check("R2/R8/R10 readback", ctrl_rd, e);
         check("R2 rate_code", {5'd0, rate_code}, {5'd0, e[7], e[1], e[0]});
         check("R2 ack_en", {7'd0, ack_en}, {7'd0, e[2]});
      end

      // R3 disabled gating
      wr(8'h00);
      eng_scl_oe = 1'b1; eng_sda_oe = 1'b1; scl_pad_in = 1'b0; sda_pad_in = 1'b0;
      @(negedge clk);
      check("R3 oe off", {6'd0, scl_oe, sda_oe}, 8'h00);
      check("R3 inputs idle", {6'd0, eng_scl_in, eng_sda_in}, 8'h03);
      eng_status_evt = 1'b1;
      @(negedge clk);
      eng_status_evt = 1'b0;
      check("R3 event ignored", {7'd0, irq}, 8'h00);
      wr(8'h40);
      check("R3 oe pass", {6'd0, scl_oe, sda_oe}, 8'h03);
      check("R3 inputs pass", {6'd0, eng_scl_in, eng_sda_in}, 8'h00);

      // R7 flag set
      eng_status_evt = 1'b1;
      @(negedge clk);
      eng_status_evt = 1'b0;
      check("R7 irq set", {7'd0, irq}, 8'h01);
      check("R7 readback flag", ctrl_rd, 8'h48);

      // R8 write 1 keeps, write 0 clears
      wr(8'h48);
      check("R8 write one keeps", {7'd0, irq}, 8'h01);
      wr(8'h40);
      check("R8 write zero clears", {7'd0, irq}, 8'h00);
      wr(8'h48);
      check("R8 cannot set", {7'd0, irq}, 8'h00);

      // R9 set beats clear
      @(negedge clk);
      bus_wr_en = 1'b1; bus_wr_data = 8'h40; eng_status_evt = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0; eng_status_evt = 1'b0;
      check("R9 set wins", {7'd0, irq}, 8'h01);
      wr(8'h40);

      // R4/R5 start
      bus_free = 1'b0;
      wr(8'h60);
      check("R4 start pending", ctrl_rd, 8'h60);
      check("R4 start held while busy", {7'd0, start_cmd}, 8'h00);
      bus_free = 1'b1;
      #1;
      check("R4 start issued when free", {7'd0, start_cmd}, 8'h01);
      @(negedge clk);
      eng_start_done = 1'b1;
      @(negedge clk);
      eng_start_done = 1'b0;
      check("R5 start cleared", ctrl_rd, 8'h40);
      check("R5 start_cmd low", {7'd0, start_cmd}, 8'h00);

      // R6 stop
      master_mode = 1'b0;
      wr(8'h50);
      check("R6 stop held if not master", {7'd0, stop_cmd}, 8'h00);
      master_mode = 1'b1;
      #1;
      check("R6 stop issued as master", {7'd0, stop_cmd}, 8'h01);
      @(negedge clk);
      eng_stop_done = 1'b1;
      @(negedge clk);
      eng_stop_done = 1'b0;
      check("R6 stop cleared", ctrl_rd, 8'h40);

      // R10 disable cancels pending requests
      bus_free = 1'b0; master_mode = 1'b0;
      wr(8'h70);
      check("R10 both pending", ctrl_rd, 8'h70);
      wr(8'h00);
      wr(8'h40);
      bus_free = 1'b1; master_mode = 1'b1;
      #1;
      check("R10 cancelled", ctrl_rd, 8'h40);
      check("R10 no commands", {6'd0, start_cmd, stop_cmd}, 8'h00);

      // R11 write beats completion
      bus_free = 1'b0;
      wr(8'h60);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_wr_data = 8'h60; eng_start_done = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0; eng_start_done = 1'b0;
      check("R11 write wins", ctrl_rd, 8'h60);

      // reset mid-run returns to zero (R1)
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset clears", ctrl_rd, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule